// File: doc/BRIEF.md
# BiSS-C Point-to-Point Frame Master

This block is the controller end of a single-slave BiSS-C position link. A one-cycle start pulse makes it drive the outgoing clock line low and toggle it a programmed number of times at a programmed rate, so that the line ends high again. The returning data line is synchronised and watched. The slave first answers with one or more low acknowledge bits and then a high start bit. The block restarts its own sample timer on the rising edge of that start bit. It then samples every later bit at its centre, whatever the cable delay and however many acknowledge bits came first.

From the sampled bits the block takes a control bit, a 13-bit Gray-coded single-turn position, and an error flag and a warning flag. Both flags are low when active. It also takes a 6-bit check word. It runs a CRC over the position and the flags as the bits arrive, compares the result with the received check word, and gives the position in binary as well. A one-cycle done strobe marks the moment all results are valid. If the slave never answers before the clock burst ends, the frame closes with a timeout flag.

Top module: `biss_frame_master`

## Requirements
- R1: After reset the clock line `ma_o` is high and `busy_o` and `done_o` are low; `ma_o` is high whenever `busy_o` is low.
- R2: A start pulse while idle raises `busy_o`. After `half_lim_i`+1 cycles the first edge on `ma_o` is a falling one, and each later edge follows `half_lim_i`+1 cycles after the one before. Exactly `edge_cnt_i` edges are produced in all (`edge_cnt_i`/2 falling edges), and the line is left high.
- R3: A start pulse while `busy_o` is high is ignored: the running frame keeps its edge count and produces exactly one done strobe.
- R4: After the start bit, the fields are taken in this order: one control bit (`cds_o`), 13 position bits MSB first (`pos_gray_o`), the error bit, the warning bit, then 6 check bits MSB first (`crc_rx_o`).
- R5: Bit sampling is timed from the rising edge of the start bit. The first sample falls half a bit period after that edge and later samples follow one full bit period (2·(`half_lim_i`+1) cycles) apart. Fields are captured correctly with 1 to 3 acknowledge bits and a line delay of up to 7 cycles.
- R6: The error and warning bits appear as received on `err_n_o` and `warn_n_o` (1 = no error or warning).
- R7: `crc_calc_o` is the CRC of the 13 position bits followed by error and warning, MSB first, with polynomial x^6+x+1 and a start value of zero. The control bit is not included. `crc_ok_o` is 1 exactly when `crc_rx_o` equals the bitwise inverse of `crc_calc_o`.
- R8: `pos_bin_o` is the binary value of `pos_gray_o`: its top bit equals the Gray top bit, and each lower bit is the XOR of the binary bit above it and the Gray bit at the same position.
- R9: If the clock burst ends while the block is still waiting for the acknowledge or start bit, it still raises `done_o`, with `timeout_o`=1 and `crc_ok_o`=0.
- R10: `done_o` is high for one cycle per frame. All result outputs change only in the cycle that `done_o` is high and hold their values until the next done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a frame |
| half_lim_i | input | 16 | Half bit period in cycles minus one |
| edge_cnt_i | input | 8 | Clock-line edges per frame (even, nonzero) |
| sl_i | input | 1 | Serial data from the slave |
| ma_o | output | 1 | Clock line to the slave, high when idle |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle strobe: results valid |
| timeout_o | output | 1 | No acknowledge or start bit seen within the burst |
| cds_o | output | 1 | Received control bit |
| pos_gray_o | output | 13 | Received position, Gray code |
| pos_bin_o | output | 13 | Position converted to binary |
| err_n_o | output | 1 | Error bit, active low |
| warn_n_o | output | 1 | Warning bit, active low |
| crc_rx_o | output | 6 | Received check word |
| crc_calc_o | output | 6 | Locally computed CRC, not inverted |
| crc_ok_o | output | 1 | Received check word matches inverted CRC |

## Verification
The checker assumes that `half_lim_i` and `edge_cnt_i` stay fixed while a frame is running, and that a frame is only launched with an even, nonzero edge count. The stimulus sets both before each start pulse and never changes them until `busy_o` has fallen. The slave model drives the data line high again only after the clock line has rested high for longer than a bit period, so that the next frame's acknowledge is never confused with the previous timeout level. The bench waits for that before it starts a new frame. Line delays stay below one half bit period plus margin, which keeps every sample inside its bit.

// File: rtl/biss_pkg.sv
package biss_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_ACK,
      RX_START,
      RX_SAMPLE,
      RX_FIN
   } rx_state_t;

   // one serial CRC step, MSB-first data, zero-free generic form
   function automatic logic [5:0] crc6_step(input logic [5:0] cur,
                                            input logic       din,
                                            input logic [5:0] poly);
      logic fb;
      fb = din ^ cur[5];
      return {cur[4:0], 1'b0} ^ (fb ? poly : 6'd0);
   endfunction

endpackage

// File: rtl/biss_sl_sync.sv
module biss_sl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sl_i,
   output logic sl_s,
   output logic sl_rise,
   output logic sl_fall
);

   initial begin
      if (STAGES < 2) $fatal(1, "biss_sl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= sl_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b1;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign sl_s    = chain[STAGES-1];
   assign sl_rise = chain[STAGES-1] & ~prev;
   assign sl_fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/biss_clk_gen.sv
module biss_clk_gen #(
   parameter int DIV_W  = 16,
   parameter int EDGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [DIV_W-1:0]  half_lim,
   input  logic [EDGE_W-1:0] edges,
   output logic              ma,
   output logic              active,
   output logic              last_edge
);

   initial begin
      if (DIV_W < 2)  $fatal(1, "biss_clk_gen: DIV_W too small");
      if (EDGE_W < 2) $fatal(1, "biss_clk_gen: EDGE_W too small");
   end

   logic [DIV_W-1:0]  cnt;
   logic [EDGE_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma        <= 1'b1;
         active    <= 1'b0;
         last_edge <= 1'b0;
         cnt       <= '0;
         left      <= '0;
      end else begin
         last_edge <= 1'b0;
         if (launch) begin
            active <= 1'b1;
            cnt    <= '0;
            left   <= edges;
            ma     <= 1'b1;
         end else if (active) begin
            if (cnt == half_lim) begin
               cnt  <= '0;
               ma   <= ~ma;
               left <= left - 1'b1;
               if (left == EDGE_W'(1)) begin
                  active    <= 1'b0;
                  last_edge <= 1'b1;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/biss_rx.sv
module biss_rx
   import biss_pkg::*;
#(
   parameter int          POS_W    = 13,
   parameter int          CRC_W    = 6,
   parameter logic [5:0]  CRC_POLY = 6'h03,
   parameter int          DIV_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             clk_last,
   input  logic [DIV_W-1:0] half_lim,
   input  logic             sl_s,
   input  logic             sl_rise,
   output logic             rx_busy,
   output logic             done_o,
   output logic             timeout_o,
   output logic             cds_o,
   output logic [POS_W-1:0] pos_gray_o,
   output logic             err_n_o,
   output logic             warn_n_o,
   output logic [CRC_W-1:0] crc_rx_o,
   output logic [CRC_W-1:0] crc_calc_o,
   output logic             crc_ok_o
);

   localparam int CDS_IDX  = 1;
   localparam int POS_LO   = 2;
   localparam int POS_HI   = POS_LO + POS_W - 1;
   localparam int ERR_IDX  = POS_HI + 1;
   localparam int WARN_IDX = POS_HI + 2;
   localparam int CRC_LO   = POS_HI + 3;
   localparam int LAST_IDX = CRC_LO + CRC_W - 1;
   localparam int IDX_W    = $clog2(LAST_IDX + 1);

   initial begin
      if (CRC_W != 6)  $fatal(1, "biss_rx: only a 6-bit check word is supported");
      if (POS_W < 2)   $fatal(1, "biss_rx: POS_W must be at least 2");
   end

   rx_state_t           state;
   logic [DIV_W:0]      tmr;
   logic [IDX_W-1:0]    bidx;
   logic                cds_r, err_r, warn_r, to_r;
   logic [POS_W-1:0]    gray_r;
   logic [CRC_W-1:0]    crx_r, crc_r;
   logic [DIV_W:0]      full_lim;
   logic [DIV_W:0]      half_ext;

   assign full_lim = {half_lim, 1'b1};
   assign half_ext = {1'b0, half_lim};
   assign rx_busy  = (state != RX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         tmr        <= '0;
         bidx       <= '0;
         cds_r      <= 1'b0;
         err_r      <= 1'b1;
         warn_r     <= 1'b1;
         to_r       <= 1'b0;
         gray_r     <= '0;
         crx_r      <= '0;
         crc_r      <= '0;
         done_o     <= 1'b0;
         timeout_o  <= 1'b0;
         cds_o      <= 1'b0;
         pos_gray_o <= '0;
         err_n_o    <= 1'b1;
         warn_n_o   <= 1'b1;
         crc_rx_o   <= '0;
         crc_calc_o <= '0;
         crc_ok_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            RX_IDLE: begin
               if (launch) begin
                  state <= RX_ACK;
                  crc_r <= '0;
                  to_r  <= 1'b0;
               end
            end
            RX_ACK: begin
               if (clk_last) begin
                  to_r  <= 1'b1;
                  state <= RX_FIN;
               end else if (!sl_s) begin
                  state <= RX_START;
               end
            end
            RX_START: begin
               if (clk_last) begin
                  to_r  <= 1'b1;
                  state <= RX_FIN;
               end else if (sl_rise) begin
                  tmr   <= half_ext;
                  bidx  <= '0;
                  state <= RX_SAMPLE;
               end
            end
            RX_SAMPLE: begin
               if (tmr == '0) begin
                  tmr  <= full_lim;
                  bidx <= bidx + 1'b1;
                  if (int'(bidx) == CDS_IDX) begin
                     cds_r <= sl_s;
                  end else if (int'(bidx) >= POS_LO && int'(bidx) <= POS_HI) begin
                     gray_r <= {gray_r[POS_W-2:0], sl_s};
                     crc_r  <= crc6_step(crc_r, sl_s, CRC_POLY);
                  end else if (int'(bidx) == ERR_IDX) begin
                     err_r <= sl_s;
                     crc_r <= crc6_step(crc_r, sl_s, CRC_POLY);
                  end else if (int'(bidx) == WARN_IDX) begin
                     warn_r <= sl_s;
                     crc_r  <= crc6_step(crc_r, sl_s, CRC_POLY);
                  end else if (int'(bidx) >= CRC_LO) begin
                     crx_r <= {crx_r[CRC_W-2:0], sl_s};
                  end
                  if (int'(bidx) == LAST_IDX) state <= RX_FIN;
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            RX_FIN: begin
               done_o     <= 1'b1;
               timeout_o  <= to_r;
               cds_o      <= cds_r;
               pos_gray_o <= gray_r;
               err_n_o    <= err_r;
               warn_n_o   <= warn_r;
               crc_rx_o   <= crx_r;
               crc_calc_o <= crc_r;
               crc_ok_o   <= !to_r && (crx_r == ~crc_r);
               state      <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/biss_gray2bin.sv
module biss_gray2bin #(
   parameter int W = 13
) (
   input  logic [W-1:0] gray,
   output logic [W-1:0] bin
);

   initial begin
      if (W < 2) $fatal(1, "biss_gray2bin: W must be at least 2");
   end

   generate
      genvar gi;
      for (gi = W - 1; gi >= 0; gi--) begin : g_bit
         if (gi == W - 1) begin : g_top
            assign bin[gi] = gray[gi];
         end else begin : g_low
            assign bin[gi] = bin[gi+1] ^ gray[gi];
         end
      end
   endgenerate

endmodule

// File: rtl/biss_frame_master.sv
module biss_frame_master #(
   parameter int         POS_W       = 13,
   parameter int         CRC_W       = 6,
   parameter logic [5:0] CRC_POLY    = 6'h03,
   parameter int         DIV_W       = 16,
   parameter int         EDGE_W      = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DIV_W-1:0]  half_lim_i,
   input  logic [EDGE_W-1:0] edge_cnt_i,
   input  logic              sl_i,
   output logic              ma_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              timeout_o,
   output logic              cds_o,
   output logic [POS_W-1:0]  pos_gray_o,
   output logic [POS_W-1:0]  pos_bin_o,
   output logic              err_n_o,
   output logic              warn_n_o,
   output logic [CRC_W-1:0]  crc_rx_o,
   output logic [CRC_W-1:0]  crc_calc_o,
   output logic              crc_ok_o
);

   logic launch, clk_active, clk_last, rx_busy;
   logic sl_s, sl_rise, sl_fall;

   assign busy_o = clk_active | rx_busy;
   assign launch = start_i & ~busy_o;

   biss_sl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sl_i    (sl_i),
      .sl_s    (sl_s),
      .sl_rise (sl_rise),
      .sl_fall (sl_fall)
   );

   biss_clk_gen #(.DIV_W(DIV_W), .EDGE_W(EDGE_W)) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .half_lim  (half_lim_i),
      .edges     (edge_cnt_i),
      .ma        (ma_o),
      .active    (clk_active),
      .last_edge (clk_last)
   );

   biss_rx #(
      .POS_W(POS_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .DIV_W(DIV_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .clk_last   (clk_last),
      .half_lim   (half_lim_i),
      .sl_s       (sl_s),
      .sl_rise    (sl_rise),
      .rx_busy    (rx_busy),
      .done_o     (done_o),
      .timeout_o  (timeout_o),
      .cds_o      (cds_o),
      .pos_gray_o (pos_gray_o),
      .err_n_o    (err_n_o),
      .warn_n_o   (warn_n_o),
      .crc_rx_o   (crc_rx_o),
      .crc_calc_o (crc_calc_o),
      .crc_ok_o   (crc_ok_o)
   );

   biss_gray2bin #(.W(POS_W)) u_g2b (
      .gray (pos_gray_o),
      .bin  (pos_bin_o)
   );

endmodule

// File: rtl/biss_frame_master_chk.sv
module biss_frame_master_chk #(
   parameter int POS_W  = 13,
   parameter int CRC_W  = 6,
   parameter int DIV_W  = 16,
   parameter int EDGE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [DIV_W-1:0]  half_lim_i,
   input logic [EDGE_W-1:0] edge_cnt_i,
   input logic              ma_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              timeout_o,
   input logic [POS_W-1:0]  pos_gray_o,
   input logic [POS_W-1:0]  pos_bin_o,
   input logic [CRC_W-1:0]  crc_rx_o,
   input logic              crc_ok_o
);

   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> ma_o);

   // R2
   busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R2
   even_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |-> (edge_cnt_i[0] == 1'b0 && edge_cnt_i != '0));

   // R5
   settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(half_lim_i) && $stable(edge_cnt_i)));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(pos_gray_o) && $stable(crc_rx_o) && $stable(crc_ok_o)));

   // R9
   timeout_no_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && timeout_o) |-> !crc_ok_o);

   // R8
   bin_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_bin_o[POS_W-1] == pos_gray_o[POS_W-1]);

endmodule

bind biss_frame_master biss_frame_master_chk #(
   .POS_W(POS_W), .CRC_W(CRC_W), .DIV_W(DIV_W), .EDGE_W(EDGE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .half_lim_i (half_lim_i),
   .edge_cnt_i (edge_cnt_i),
   .ma_o       (ma_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .timeout_o  (timeout_o),
   .pos_gray_o (pos_gray_o),
   .pos_bin_o  (pos_bin_o),
   .crc_rx_o   (crc_rx_o),
   .crc_ok_o   (crc_ok_o)
);

// File: tb/biss_frame_master_tb.sv
module biss_frame_master_tb;

   typedef struct {
      logic [12:0] gray;
      logic [12:0] bin;
      logic        cds, e, w, ok, to;
      logic [5:0]  crx, ccalc;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] half_lim = 16'd9;
   logic [7:0]  edge_cnt = 8'd52;
   logic        sl;
   logic        ma, busy, done, to, cds, err_n, warn_n, crc_ok;
   logic [12:0] pgray, pbin;
   logic [5:0]  crx, ccalc;

   int checks = 0, failures = 0, cyc = 0;
   int falls = 0, dones = 0, low_run = 0, low_len = 0;
   exp_t q[$];

   always #4 clk = ~clk;

   biss_frame_master u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .half_lim_i(half_lim),
      .edge_cnt_i(edge_cnt), .sl_i(sl), .ma_o(ma), .busy_o(busy),
      .done_o(done), .timeout_o(to), .cds_o(cds), .pos_gray_o(pgray),
      .pos_bin_o(pbin), .err_n_o(err_n), .warn_n_o(warn_n),
      .crc_rx_o(crx), .crc_calc_o(ccalc), .crc_ok_o(crc_ok)
   );

   // ---------------- slave model ----------------
   logic [21:0] fbits = '0;
   int          nack = 1, ldly = 0, rc = 0, hi_cnt = 0, n_v;
   bit          enc_on = 1'b1, tout = 1'b0;
   logic        sl_raw = 1'b1, ma_q = 1'b1;
   logic [15:0] dly = '1;

   always @(posedge clk) begin
      ma_q <= ma;
      dly  <= {dly[14:0], sl_raw};
      if (tout) begin
         hi_cnt <= ma ? hi_cnt + 1 : 0;
         if (hi_cnt >= 40) begin
            sl_raw <= 1'b1;
            tout   <= 1'b0;
            rc     <= 0;
         end
      end else if (enc_on && ma && !ma_q) begin
         n_v = rc + 1;
         rc <= n_v;
         if (n_v >= 2 && n_v <= 1 + nack) sl_raw <= 1'b0;
         else if (n_v == 2 + nack) sl_raw <= 1'b1;
         else if (n_v > 2 + nack && n_v <= 24 + nack) sl_raw <= fbits[21-(n_v-3-nack)];
         else if (n_v == 25 + nack) begin
            sl_raw <= 1'b0;
            tout   <= 1'b1;
            hi_cnt <= 0;
         end
      end
   end

   assign sl = (ldly == 0) ? sl_raw : dly[ldly-1];

   // ---------------- observers ----------------
   logic ma_p = 1'b1;
   always @(posedge clk) begin
      ma_p <= ma;
      if (ma_p && !ma) falls <= falls + 1;
      if (!ma) low_run <= low_run + 1;
      else begin
         if (!ma_p) low_len <= low_run;
         low_run <= 0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: %s", req, what);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         exp_t e;
         dones <= dones + 1;
         if (q.size() == 0) chk(1'b0, "R10", "done with nothing expected");
         else begin
            e = q.pop_front();
            chk(to == e.to, "R9", $sformatf("timeout act=%0b exp=%0b", to, e.to));
            chk(crc_ok == e.ok, "R7", $sformatf("crc_ok act=%0b exp=%0b", crc_ok, e.ok));
            if (!e.to) begin
               chk(pgray == e.gray, "R4", $sformatf("gray act=%h exp=%h", pgray, e.gray));
               chk(cds == e.cds, "R4", $sformatf("cds act=%0b exp=%0b", cds, e.cds));
               chk(pbin == e.bin, "R8", $sformatf("bin act=%h exp=%h", pbin, e.bin));
               chk({err_n, warn_n} == {e.e, e.w}, "R6",
                   $sformatf("flags act=%b%b exp=%b%b", err_n, warn_n, e.e, e.w));
               chk(crx == e.crx, "R5", $sformatf("crc_rx act=%h exp=%h", crx, e.crx));
               chk(ccalc == e.ccalc, "R7", $sformatf("crc_calc act=%h exp=%h", ccalc, e.ccalc));
            end
         end
      end
   end

   function automatic logic [5:0] ref_crc(input logic [14:0] d);
      logic [5:0] c = '0;
      for (int i = 14; i >= 0; i--) begin
         logic fb = d[i] ^ c[5];
         c = {c[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b0);
      end
      return c;
   endfunction

   task automatic run_frame(input bit c, input logic [12:0] b, input bit e, input bit w,
                            input int na, input int dl, input int edges,
                            input bit bad, input bit on, input bit restart);
      exp_t x;
      logic [12:0] g = b ^ (b >> 1);
      logic [5:0]  cc = ref_crc({g, e, w});
      logic [5:0]  tx = ~cc ^ (bad ? 6'h01 : 6'h00);
      fbits    = {c, g, e, w, tx};
      nack     = na;
      ldly     = dl;
      enc_on   = on;
      edge_cnt = 8'(edges);
      x.gray = g; x.bin = b; x.cds = c; x.e = e; x.w = w;
      x.crx = tx; x.ccalc = cc; x.to = !on; x.ok = on && !bad;
      q.push_back(x);
      falls = 0;
      dones = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (restart) begin
         repeat (100) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      do @(negedge clk); while (busy);
      repeat (80) @(negedge clk);
      chk(falls == edges / 2, "R2", $sformatf("falls act=%0d exp=%0d", falls, edges / 2));
      chk(ma == 1'b1, "R2", $sformatf("ma after frame act=%0b exp=1", ma));
      chk(dones == 1, "R3", $sformatf("done count act=%0d exp=1", dones));
      if (on) chk(pgray == g, "R10", $sformatf("held gray act=%h exp=%h", pgray, g));
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ma == 1'b1 && busy == 1'b0 && done == 1'b0, "R1",
          $sformatf("reset ma/busy/done act=%b%b%b exp=100", ma, busy, done));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(ma == 1'b1, "R1", $sformatf("idle ma act=%0b exp=1", ma));
      // R4 R7 basic frame
      run_frame(1'b0, 13'h0A5C, 1'b1, 1'b1, 1, 0, 52, 1'b0, 1'b1, 1'b0);
      chk(low_len == 10, "R2", $sformatf("low phase act=%0d exp=10", low_len));
      // R5 long delay and extra acknowledge bits
      run_frame(1'b0, 13'h1FFF, 1'b0, 1'b1, 3, 7, 60, 1'b0, 1'b1, 1'b0);
      // R7 control bit outside CRC, R6 warning active
      run_frame(1'b1, 13'h0000, 1'b1, 1'b0, 2, 3, 56, 1'b0, 1'b1, 1'b0);
      run_frame(1'b0, 13'h0000, 1'b1, 1'b0, 2, 3, 56, 1'b0, 1'b1, 1'b0);
      // R7 corrupted check word
      run_frame(1'b1, 13'h1234, 1'b1, 1'b1, 1, 2, 52, 1'b1, 1'b1, 1'b0);
      // R3 second start during frame
      run_frame(1'b0, 13'h0ACE, 1'b0, 1'b0, 1, 1, 54, 1'b0, 1'b1, 1'b1);
      // R9 silent slave
      run_frame(1'b0, 13'h0000, 1'b1, 1'b1, 1, 0, 52, 1'b0, 1'b0, 1'b0);
      // recovery after timeout
      run_frame(1'b1, 13'h1000, 1'b1, 1'b1, 1, 5, 52, 1'b0, 1'b1, 1'b0);
      chk(q.size() == 0, "R10", $sformatf("pending items act=%0d exp=0", q.size()));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule